// File: doc/BRIEF.md
# Partitioned Frame Read Sequencer

This block walks a monochrome frame buffer of 32 KB that holds a 256 by 1024 pixel picture split into 16 horizontal bands (partitions) of 16 rows each. While its scan enable is high, it issues one buffer read address on every clock. Alongside each address it pulls low exactly one of sixteen select lines, so that the byte coming back from memory is captured by the latch that belongs to that band.

The address is built so that the band index changes fastest. Sixteen consecutive reads therefore fetch the same column byte from every band in turn. After that the column byte advances, and after all 128 column bytes of a row the row advances. A one-cycle done pulse marks the read that ends the frame, and the sequence then starts again at address zero. Clearing the enable freezes the sequence and releases every select line.

Top module: `pscan_read_seq`

## Requirements
- R1: After reset, and before any enabled cycle, the address output is 0x0000, all sixteen select lines are high, and the done output is low.
- R2: Bit 15 of the address output is always 0.
- R3: The band index sits in address bits [3:0]. It increases by one on every enabled cycle, so sixteen consecutive reads carry the same bits [14:4] with bands 0 to 15 in order.
- R4: The column byte sits in address bits [10:4]. It increases by one on the read that follows band 15.
- R5: The row sits in address bits [14:11]. It increases by one on the read that follows band 15 of column byte 127.
- R6: Select lines are active low. After each enabled cycle exactly one line is low, and its index equals address bits [3:0].
- R7: After a cycle with the enable low, every select line is high, done is low, and the address output holds its last value. The sequence resumes at the next address when the enable returns.
- R8: The done output is high for exactly the one cycle in which address 0x7FFF is presented. The following enabled read presents address 0x0000.
- R9: The address, select and done outputs are registered. They reflect the enable sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Read clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scan_en_i | input | 1 | Issue a read this cycle when high; pause when low |
| rd_addr_o | output | 16 | Buffer read address: {0, row, column byte, band} |
| part_sel_n_o | output | 16 | Active-low band latch selects |
| frame_done_o | output | 1 | High for the read of the last address in the frame |

## Verification
A corrupted band, column or row counter shows at the address port on the very next enabled read: it breaks the step of one from the previous address, and the bench model flags it at once. A wrong carry between fields shows up as an address that jumps or repeats at a band 15 or column byte 127 boundary. A bad decoder or a missing pause gate shows on the select lines in the same cycle. A late or missing end-of-frame flag appears after 32768 enabled reads, which a full-frame run covers.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  localparam int unsigned PART_W_DEF = 4;
  localparam int unsigned COL_W_DEF  = 7;
  localparam int unsigned ROW_W_DEF  = 4;
  localparam int unsigned ADDR_W_DEF = 16;
endpackage

// File: rtl/pscan_rst_sync.sv
module pscan_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/pscan_field_ctr.sv
module pscan_field_ctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (inc_i) val_d = val_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) val_q <= '0;
    else          val_q <= val_d;
  end

  assign val_o  = val_q;
  assign wrap_o = inc_i && (val_q == TOP);
endmodule

// File: rtl/pscan_sel_dec.sv
module pscan_sel_dec #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned N     = 1 << IDX_W
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     sel_n_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign sel_n_o[i] = ~(en_i && (idx_i == IDX_W'(i)));
  end
endmodule

// File: rtl/pscan_read_seq.sv
module pscan_read_seq
  import pscan_pkg::*;
#(
  parameter int unsigned PART_W = PART_W_DEF,
  parameter int unsigned COL_W  = COL_W_DEF,
  parameter int unsigned ROW_W  = ROW_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic                   clk_i,
  input  logic                   rst_n_i,
  input  logic                   scan_en_i,
  output logic [ADDR_W-1:0]      rd_addr_o,
  output logic [(1<<PART_W)-1:0] part_sel_n_o,
  output logic                   frame_done_o
);
  localparam int unsigned FIELD_W = PART_W + COL_W + ROW_W;
  localparam int unsigned NSEL    = 1 << PART_W;

  logic rst_core_n;

  pscan_rst_sync i_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_core_n)
  );

  // Field counters: band fastest, then column byte, then row.
  logic [PART_W-1:0] part_val;
  logic [COL_W-1:0]  col_val;
  logic [ROW_W-1:0]  row_val;
  logic              part_wrap;
  logic              col_wrap;
  logic              row_wrap;

  pscan_field_ctr #(.W(PART_W)) i_part_ctr (
    .clk_i   (clk_i),
    .rst_n_i (rst_core_n),
    .inc_i   (scan_en_i),
    .val_o   (part_val),
    .wrap_o  (part_wrap)
  );

  pscan_field_ctr #(.W(COL_W)) i_col_ctr (
    .clk_i   (clk_i),
    .rst_n_i (rst_core_n),
    .inc_i   (part_wrap),
    .val_o   (col_val),
    .wrap_o  (col_wrap)
  );

  pscan_field_ctr #(.W(ROW_W)) i_row_ctr (
    .clk_i   (clk_i),
    .rst_n_i (rst_core_n),
    .inc_i   (col_wrap),
    .val_o   (row_val),
    .wrap_o  (row_wrap)
  );

  logic [FIELD_W-1:0] cur_field;
  assign cur_field = {row_val, col_val, part_val};

  logic [NSEL-1:0] sel_n_d;

  pscan_sel_dec #(.IDX_W(PART_W), .N(NSEL)) i_sel_dec (
    .en_i    (scan_en_i),
    .idx_i   (part_val),
    .sel_n_o (sel_n_d)
  );

  // Output stage.
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic [NSEL-1:0]   sel_n_q;
  logic              done_q;
  logic              done_d;

  always_comb begin
    addr_d = addr_q;
    if (scan_en_i) addr_d = ADDR_W'(cur_field);
    done_d = row_wrap;
  end

  always_ff @(posedge clk_i or negedge rst_core_n) begin
    if (!rst_core_n) begin
      addr_q  <= '0;
      sel_n_q <= '1;
      done_q  <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      sel_n_q <= sel_n_d;
      done_q  <= done_d;
    end
  end

  assign rd_addr_o    = addr_q;
  assign part_sel_n_o = sel_n_q;
  assign frame_done_o = done_q;
endmodule

// File: rtl/pscan_read_seq_chk.sv
module pscan_read_seq_chk #(
  parameter int unsigned PART_W = 4,
  parameter int unsigned COL_W  = 7,
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned ADDR_W = 16
) (
  input logic                   clk_i,
  input logic                   rst_n_i,
  input logic                   scan_en_i,
  input logic [ADDR_W-1:0]      rd_addr_o,
  input logic [(1<<PART_W)-1:0] part_sel_n_o,
  input logic                   frame_done_o
);
  localparam int unsigned FIELD_W = PART_W + COL_W + ROW_W;
  localparam int unsigned NSEL    = 1 << PART_W;

  logic any_q;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)       any_q <= 1'b0;
    else if (scan_en_i) any_q <= 1'b1;
  end

  a_r2_msb_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rd_addr_o >> FIELD_W) == '0);

  a_r1_first_read_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (scan_en_i && !any_q) |=> (rd_addr_o == '0));

  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (scan_en_i && any_q) |=>
      (rd_addr_o[FIELD_W-1:0] == FIELD_W'($past(rd_addr_o[FIELD_W-1:0]) + 1'b1)));

  a_r6_single_select: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    scan_en_i |=> ($countones(~part_sel_n_o) == 1));

  a_r6_select_index: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    scan_en_i |=> (~part_sel_n_o == (NSEL'(1) << rd_addr_o[PART_W-1:0])));

  a_r7_idle_release: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !scan_en_i |=> ((&part_sel_n_o) && !frame_done_o));

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !scan_en_i |=> $stable(rd_addr_o));

  a_r8_done_at_last: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    frame_done_o |-> (rd_addr_o[FIELD_W-1:0] == '1));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    frame_done_o |=> !frame_done_o);
endmodule

bind pscan_read_seq pscan_read_seq_chk #(
  .PART_W (PART_W),
  .COL_W  (COL_W),
  .ROW_W  (ROW_W),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_n_i      (rst_core_n),
  .scan_en_i    (scan_en_i),
  .rd_addr_o    (rd_addr_o),
  .part_sel_n_o (part_sel_n_o),
  .frame_done_o (frame_done_o)
);

// File: tb/test_pscan_read_seq.sv
module test_pscan_read_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [15:0] addr;
  logic [15:0] sel_n;
  logic        done;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [15:0] model;     // next address to be issued
  logic [15:0] last_addr; // last issued address

  always #4 clk = ~clk;

  pscan_read_seq i_pscan_read_seq (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .scan_en_i    (en),
    .rd_addr_o    (addr),
    .part_sel_n_o (sel_n),
    .frame_done_o (done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive enable at negedge, sample just after the edge.
  task automatic step(input logic e);
    logic [15:0] issued;
    string tag;
    @(negedge clk);
    en = e;
    @(posedge clk);
    #1;
    if (e) begin
      issued    = model;
      last_addr = model;
      model     = (model + 16'd1) & 16'h7FFF;
      if (issued[3:0] == 4'd0 && issued[10:4] == 7'd0 && issued != 16'd0) tag = "R5 row advance";
      else if (issued[3:0] == 4'd0 && issued != 16'd0) tag = "R4 column advance";
      else tag = "R3 band step";
      chk(addr == issued, tag, addr, issued);
      chk(addr[15] == 1'b0, "R2 msb", addr[15], 0);
      chk(sel_n == ~(16'd1 << issued[3:0]), "R6 select", sel_n, ~(16'd1 << issued[3:0]));
      chk(done == (issued == 16'h7FFF), "R8 done", done, issued == 16'h7FFF);
    end else begin
      chk(sel_n == 16'hFFFF, "R7 idle select", sel_n, 16'hFFFF);
      chk(done == 1'b0, "R7 idle done", done, 0);
      chk(addr == last_addr, "R7 idle hold", addr, last_addr);
    end
  endtask

  task automatic t_reset;
    en    = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    model     = 16'd0;
    last_addr = 16'd0;
    chk(addr == 16'd0, "R1 reset addr", addr, 0);
    chk(sel_n == 16'hFFFF, "R1 reset select", sel_n, 16'hFFFF);
    chk(done == 1'b0, "R1 reset done", done, 0);
  endtask

  task automatic t_latency;
    // R9: outputs change only after the edge that samples enable.
    @(negedge clk);
    en = 1'b1;
    #1;
    chk(sel_n == 16'hFFFF, "R9 no change before edge", sel_n, 16'hFFFF);
    @(posedge clk);
    #1;
    chk(addr == model && sel_n == 16'hFFFE, "R9 registered issue", addr, model);
    last_addr = model;
    model     = model + 16'd1;
  endtask

  task automatic t_band_sweep;
    logic [10:0] upper;
    for (int i = 0; i < 15; i++) step(1'b1);
    // A full group of 16 shares bits [14:4].
    upper = addr[14:4];
    for (int i = 0; i < 16; i++) begin
      step(1'b1);
      chk(addr[14:4] == 11'd1, "R3 same column across bands", addr[14:4], 11'd1);
      chk(addr[3:0] == 4'(i), "R3 band order", addr[3:0], i);
    end
    chk(upper == 11'd0, "R4 first group column", upper, 0);
  endtask

  task automatic t_pause;
    step(1'b0);
    step(1'b0);
    step(1'b1);
    step(1'b0);
    for (int i = 0; i < 6; i++) step(1'b1);
    step(1'b0);
    step(1'b1);
  endtask

  task automatic t_full_frame;
    // Run through a row boundary, then to the frame end, and past the wrap.
    while (model != 16'h0000) step(1'b1);
    chk(last_addr == 16'h7FFF, "R8 last before wrap", last_addr, 16'h7FFF);
    step(1'b1);
    chk(addr == 16'h0000 && done == 1'b0, "R8 wrap to zero", addr, 0);
    step(1'b1);
    step(1'b0);
  endtask

  initial begin
    en    = 1'b0;
    rst_n = 1'b0;
    t_reset();
    t_latency();
    t_band_sweep();
    t_pause();
    t_full_frame();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule